// File: doc/BRIEF.md
# Vector Address Generation Unit

This block decodes one instruction from a family of vector address-compute operations and executes it across a whole vector register. Every lane of the result is a base element plus an offset element shifted left by 0 to 3 bit positions. Two instruction bits choose the lane layout: packed 32-bit lanes, packed 64-bit lanes, or 64-bit lanes whose offset is taken only from the low 32 bits of each element, either sign-extended or zero-extended.

The surrounding pipeline supplies the instruction word together with the values of the base register, the offset register and the current destination register. It receives back the new destination value, the three register indices taken from the instruction, and a flag that marks a non-matching instruction. For a non-matching instruction the destination value passes through unchanged. The result is registered, so it appears one cycle after the request. The vector length is set as a multiple of 128 bits.

Top module: `vaddr_gen`

## Requirements
- R1: An instruction is accepted when bits [31:24] equal 8'b00000100, bit 21 is 1 and bits [15:12] equal 4'b1010. Any other word gives out_illegal = 1 and out_vec equal to dest_vec. An accepted word gives out_illegal = 0.
- R2: Variant code 2'b10 in bits [23:22] treats the vector as packed 32-bit lanes. Each lane is base + (offset << sh), kept modulo 2^32.
- R3: Variant code 2'b11 treats the vector as packed 64-bit lanes. Each lane is base + (offset << sh), kept modulo 2^64.
- R4: Variant code 2'b00 uses 64-bit lanes. Bits [31:0] of each offset element are sign-extended to 64 bits, shifted and added to the base, and offset bits [63:32] have no effect on the result.
- R5: Variant code 2'b01 uses 64-bit lanes. Bits [31:0] of each offset element are zero-extended to 64 bits, shifted and added to the base, and offset bits [63:32] have no effect on the result.
- R6: The shift amount is instruction bits [11:10], from 0 to 3, and every lane uses the same amount.
- R7: out_offs_idx is bits [20:16] of the instruction, out_base_idx is bits [9:5] and out_dst_idx is bits [4:0].
- R8: A request with in_valid = 1 gives out_valid = 1 exactly one cycle later, and a cycle with in_valid = 0 gives out_valid = 0 one cycle later. While in_valid is 0, out_vec, out_illegal and the indices keep their values. A synchronous active-high reset clears out_valid, out_illegal and out_vec.
- R9: Lane 0 occupies the least significant bits of the vector buses, and carries out of a lane are discarded rather than passed into the next lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| base_vec | input | 128*VL_UNITS | Base register value |
| offs_vec | input | 128*VL_UNITS | Offset register value |
| dest_vec | input | 128*VL_UNITS | Current destination register value |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Instruction did not match the pattern |
| out_vec | output | 128*VL_UNITS | New destination value |
| out_dst_idx | output | 5 | Destination register index |
| out_base_idx | output | 5 | Base register index |
| out_offs_idx | output | 5 | Offset register index |

## Verification
A wrong variant select or a wrong extension of the offset shows in out_vec one cycle after the request. The bench makes the two cases differ by driving offsets with bit 31 set and with nonzero upper halves. Carry that leaks between 32-bit lanes, or a shift taken from the wrong field, shows in the same cycle as a lane value that differs from the model. A decode error shows at once as a wrong out_illegal. It also shows as a destination that does not pass through, or as wrong index outputs. The hold and valid behaviour is checked on the cycle that follows an idle input.

// File: rtl/vaddr_pkg.sv
`timescale 1ns/1ps
package vaddr_pkg;

    localparam logic [7:0] MATCH_HI  = 8'b0000_0100;
    localparam logic [3:0] MATCH_MID = 4'b1010;

    typedef enum logic [1:0] {
        KIND_S32 = 2'b00,
        KIND_U32 = 2'b01,
        KIND_P32 = 2'b10,
        KIND_P64 = 2'b11
    } adr_kind_e;

    typedef struct packed {
        logic      ok;
        adr_kind_e kind;
        logic [1:0] sh;
        logic [4:0] rm;
        logic [4:0] rn;
        logic [4:0] rd;
    } adr_dec_t;

endpackage

// File: rtl/vaddr_decode.sv
`timescale 1ns/1ps
module vaddr_decode
    import vaddr_pkg::*;
(
    input  logic [31:0] instr,
    output adr_dec_t    dec
);
    always_comb begin
        dec.ok   = (instr[31:24] == MATCH_HI) && instr[21] && (instr[15:12] == MATCH_MID);
        dec.kind = adr_kind_e'(instr[23:22]);
        dec.sh   = instr[11:10];
        dec.rm   = instr[20:16];
        dec.rn   = instr[9:5];
        dec.rd   = instr[4:0];
    end
endmodule

// File: rtl/vaddr_chunk.sv
`timescale 1ns/1ps
module vaddr_chunk
    import vaddr_pkg::*;
(
    input  adr_kind_e   kind,
    input  logic [1:0]  sh,
    input  logic [63:0] base,
    input  logic [63:0] offs,
    output logic [63:0] res
);
    logic [63:0] offs_ext;
    logic [63:0] offs_sh;
    logic [31:0] lo_sh;
    logic [31:0] hi_sh;
    logic [31:0] lo_sum;
    logic [31:0] hi_sum;

    always_comb begin
        case (kind)
            KIND_S32: offs_ext = {{32{offs[31]}}, offs[31:0]};
            KIND_U32: offs_ext = {32'd0, offs[31:0]};
            default:  offs_ext = offs;
        endcase
        offs_sh = offs_ext << sh;
        lo_sh   = offs[31:0] << sh;
        hi_sh   = offs[63:32] << sh;
        lo_sum  = base[31:0] + lo_sh;
        hi_sum  = base[63:32] + hi_sh;
        if (kind == KIND_P32) begin
            res = {hi_sum, lo_sum};
        end else begin
            res = base + offs_sh;
        end
    end
endmodule

// File: rtl/vaddr_gen.sv
`timescale 1ns/1ps
module vaddr_gen
    import vaddr_pkg::*;
#(
    parameter int VL_UNITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [31:0]             instr,
    input  logic [128*VL_UNITS-1:0] base_vec,
    input  logic [128*VL_UNITS-1:0] offs_vec,
    input  logic [128*VL_UNITS-1:0] dest_vec,
    output logic                    out_valid,
    output logic                    out_illegal,
    output logic [128*VL_UNITS-1:0] out_vec,
    output logic [4:0]              out_dst_idx,
    output logic [4:0]              out_base_idx,
    output logic [4:0]              out_offs_idx
);
    localparam int VW = 128 * VL_UNITS;
    localparam int NCHUNK = VW / 64;

    typedef struct packed {
        logic          valid;
        logic          illegal;
        logic [VW-1:0] vec;
        logic [4:0]    rd;
        logic [4:0]    rn;
        logic [4:0]    rm;
    } state_t;

    adr_dec_t      dec;
    logic [VW-1:0] calc;
    state_t        st_d;
    state_t        st_q;

    vaddr_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        vaddr_chunk u_chunk (
            .kind (dec.kind),
            .sh   (dec.sh),
            .base (base_vec[c*64 +: 64]),
            .offs (offs_vec[c*64 +: 64]),
            .res  (calc[c*64 +: 64])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = !dec.ok;
            st_d.vec     = dec.ok ? calc : dest_vec;
            st_d.rd      = dec.rd;
            st_d.rn      = dec.rn;
            st_d.rm      = dec.rm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_illegal  = st_q.illegal;
    assign out_vec      = st_q.vec;
    assign out_dst_idx  = st_q.rd;
    assign out_base_idx = st_q.rn;
    assign out_offs_idx = st_q.rm;
endmodule

// File: rtl/vaddr_gen_chk.sv
`timescale 1ns/1ps
module vaddr_gen_chk #(
    parameter int VL_UNITS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [31:0]             instr,
    input logic [128*VL_UNITS-1:0] base_vec,
    input logic [128*VL_UNITS-1:0] offs_vec,
    input logic [128*VL_UNITS-1:0] dest_vec,
    input logic                    out_valid,
    input logic                    out_illegal,
    input logic [128*VL_UNITS-1:0] out_vec,
    input logic [4:0]              out_dst_idx,
    input logic [4:0]              out_base_idx,
    input logic [4:0]              out_offs_idx
);
    logic pattern_ok;
    assign pattern_ok = (instr[31:24] == 8'h04) && instr[21] && (instr[15:12] == 4'hA);

    // R8: reset clears the result flags
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal));

    // R8: one-cycle latency of valid
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && $stable(out_illegal) && $stable(out_dst_idx)));

    // R1: non-matching word keeps destination
    a_r1_illegal_passes_dest: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pattern_ok) |=> (out_illegal && out_vec == $past(dest_vec)));

    a_r1_legal_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pattern_ok) |=> !out_illegal);

    // R7: index fields
    a_r7_fields: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dst_idx == $past(instr[4:0]) && out_base_idx == $past(instr[9:5])
                      && out_offs_idx == $past(instr[20:16])));

    // R3: zero offset in packed 64-bit mode returns the base
    a_r3_zero_offset: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pattern_ok && instr[23:22] == 2'b11 && offs_vec == '0)
            |=> out_vec == $past(base_vec));
endmodule

bind vaddr_gen vaddr_gen_chk #(.VL_UNITS(VL_UNITS)) u_chk (.*);

// File: tb/sim_vaddr_gen.sv
`timescale 1ns/1ps
module sim_vaddr_gen;
    localparam int VL_UNITS = 2;
    localparam int VW = 128 * VL_UNITS;
    localparam int NCH = VW / 64;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic [31:0]    instr;
    logic [VW-1:0]  base_vec, offs_vec, dest_vec;
    logic           out_valid, out_illegal;
    logic [VW-1:0]  out_vec;
    logic [4:0]     out_dst_idx, out_base_idx, out_offs_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vaddr_gen #(.VL_UNITS(VL_UNITS)) u0 (.*);

    function automatic logic [31:0] mk(logic [1:0] kind, logic [4:0] rm, logic [1:0] sh,
                                       logic [4:0] rn, logic [4:0] rd);
        return {8'b0000_0100, kind, 1'b1, rm, 4'b1010, sh, rn, rd};
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] model(logic [1:0] kind, logic [1:0] sh,
                                            logic [VW-1:0] b, logic [VW-1:0] o);
        logic [VW-1:0] r;
        for (int c = 0; c < NCH; c++) begin
            logic [63:0] bb, oo, wide;
            logic [31:0] a0, a1;
            bb = b[c*64 +: 64];
            oo = o[c*64 +: 64];
            if (kind == 2'b10) begin
                a0 = bb[31:0] + (oo[31:0] << sh);
                a1 = bb[63:32] + (oo[63:32] << sh);
                r[c*64 +: 64] = {a1, a0};
            end else begin
                if (kind == 2'b11) wide = oo;
                else if (kind == 2'b00) wide = 64'($signed(oo[31:0]));
                else wide = {32'd0, oo[31:0]};
                r[c*64 +: 64] = bb + (wide << sh);
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request at a negedge, check at the following negedge
    task automatic issue(logic [31:0] w, logic [VW-1:0] b, logic [VW-1:0] o, logic [VW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; instr = w; base_vec = b; offs_vec = o; dest_vec = d;
        @(negedge clk);
        in_valid = 1'b0; instr = $urandom; base_vec = rnd_vec(); offs_vec = rnd_vec();
    endtask

    task automatic run_legal(string req, logic [1:0] kind, logic [1:0] sh,
                             logic [VW-1:0] b, logic [VW-1:0] o);
        issue(mk(kind, 5'd3, sh, 5'd7, 5'd12), b, o, rnd_vec());
        check({req, " valid"}, VW'(out_valid), VW'(1));
        check({req, " illegal"}, VW'(out_illegal), VW'(0));
        check({req, " vec"}, out_vec, model(kind, sh, b, o));
    endtask

    task automatic t_reset();
        check("R8 reset valid", VW'(out_valid), VW'(0));
        check("R8 reset illegal", VW'(out_illegal), VW'(0));
        check("R8 reset vec", out_vec, '0);
    endtask

    task automatic t_packed32();
        for (int i = 0; i < 4; i++) run_legal("R2", 2'b10, 2'($urandom), rnd_vec(), rnd_vec());
    endtask

    task automatic t_packed64();
        for (int i = 0; i < 4; i++) run_legal("R3", 2'b11, 2'($urandom), rnd_vec(), rnd_vec());
        run_legal("R3 wrap", 2'b11, 2'd3, {VW{1'b1}}, {VW{1'b1}});
    endtask

    task automatic t_ext(string req, logic [1:0] kind);
        logic [VW-1:0] o, o2, b;
        b = rnd_vec();
        o = rnd_vec();
        for (int c = 0; c < NCH; c++) o[c*64 + 31] = 1'b1;
        run_legal(req, kind, 2'd1, b, o);
        // change only upper halves: result must not change
        o2 = o;
        for (int c = 0; c < NCH; c++) o2[c*64 + 32 +: 32] = ~o[c*64 + 32 +: 32];
        issue(mk(kind, 5'd1, 2'd1, 5'd2, 5'd3), b, o2, rnd_vec());
        check({req, " upper ignored"}, out_vec, model(kind, 2'd1, b, o));
    endtask

    task automatic t_shift();
        logic [VW-1:0] b, o;
        b = rnd_vec();
        o = rnd_vec();
        for (int s = 0; s < 4; s++) run_legal("R6 shift", 2'b11, 2'(s), b, o);
        // offset 1 in every 64-bit lane, shift 3: each lane gains 8
        issue(mk(2'b11, 5'd0, 2'd3, 5'd0, 5'd0), '0, {NCH{64'd1}}, '0);
        check("R6 uniform", out_vec, {NCH{64'd8}});
    endtask

    task automatic t_lanes();
        logic [VW-1:0] b;
        b = '0; b[0] = 1'b1;
        issue(mk(2'b10, 5'd0, 2'd0, 5'd0, 5'd0), b, '0, '0);
        check("R9 lane0 lsb", out_vec, VW'(1));
        issue(mk(2'b10, 5'd0, 2'd0, 5'd0, 5'd0), {VW{1'b1}}, {{(VW-32){1'b0}}, 32'd1}, '0);
        check("R9 no carry across lanes", out_vec, {{(VW-32){1'b1}}, 32'd0});
    endtask

    task automatic t_illegal();
        logic [31:0] good, bad [4];
        logic [VW-1:0] d;
        good = mk(2'b11, 5'd4, 2'd2, 5'd5, 5'd6);
        bad[0] = good ^ 32'h0100_0000;
        bad[1] = good ^ 32'h0020_0000;
        bad[2] = good ^ 32'h0000_1000;
        bad[3] = good ^ 32'h8000_0000;
        for (int i = 0; i < 4; i++) begin
            d = rnd_vec();
            issue(bad[i], rnd_vec(), rnd_vec(), d);
            check("R1 illegal flag", VW'(out_illegal), VW'(1));
            check("R1 dest kept", out_vec, d);
        end
    endtask

    task automatic t_fields();
        issue(mk(2'b01, 5'd17, 2'd0, 5'd9, 5'd30), rnd_vec(), rnd_vec(), rnd_vec());
        check("R7 dst", VW'(out_dst_idx), VW'(30));
        check("R7 base", VW'(out_base_idx), VW'(9));
        check("R7 offs", VW'(out_offs_idx), VW'(17));
    endtask

    task automatic t_hold();
        logic [VW-1:0] keep;
        run_legal("R8 latency", 2'b11, 2'd0, rnd_vec(), rnd_vec());
        keep = out_vec;
        @(negedge clk);
        check("R8 idle valid", VW'(out_valid), VW'(0));
        check("R8 idle hold", out_vec, keep);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0;
        base_vec = '0; offs_vec = '0; dest_vec = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_packed32();
        t_packed64();
        t_ext("R4 signed", 2'b00);
        t_ext("R5 unsigned", 2'b01);
        t_shift();
        t_lanes();
        t_illegal();
        t_fields();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule